// File: doc/BRIEF.md
# Sign-Corrected Byte Multiply Unit

This block multiplies two byte operands. In unsigned mode the full 16-bit product is written into a pair of product byte registers on the clock edge that accepts the start strobe. The unsigned result is valid one cycle after that edge.

In signed mode the block does not use a signed multiplier array. It writes the same unsigned product first. It then steps through a fixed sequence that corrects the high byte. The first correction subtracts the first operand when the second operand is negative. The second correction subtracts the second operand when the first operand is negative. Both subtractions are modulo 256, and the low byte is never touched after the first write.

A busy flag covers the sequence, and a one-cycle done pulse marks the final value. The block drives no status flags of any kind.

Top module: `smul_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, that edge clears `prod_hi`, `prod_lo`, `busy` and `done` to zero.
- R2: A `start` high with `sgn_mode`=0 while `busy`=0 makes the next edge load {`prod_hi`,`prod_lo`} with the unsigned product `opa`*`opb`. `done` is then 1 for that one cycle, and `busy` stays 0.
- R3: A `start` high with `sgn_mode`=1 while `busy`=0 is accepted at an edge. Counting that edge as the first, the sixth edge leaves {`prod_hi`,`prod_lo`} equal to the two's-complement product of `opa` and `opb`, and raises `done` for one cycle.
- R4: After a signed start is accepted, `busy` is 1 for exactly the five cycles between the accepting edge and the sixth edge. `busy` and `done` are never 1 together.
- R5: A `start` that arrives while `busy`=1 is ignored. The sequence, its timing and its result are unchanged.
- R6: Operands are captured at the accepting edge. Changes on `opa`, `opb` or `sgn_mode` during a signed sequence have no effect on the result.
- R7: During a signed sequence, `prod_lo` keeps the low byte of the unsigned product it received at the accepting edge.
- R8: The high-byte corrections follow a fixed order. At the third edge, if bit 7 of the captured `opb` is set, `prod_hi` drops by the captured `opa` (mod 256). At the sixth edge, if bit 7 of the captured `opa` is set, `prod_hi` drops by the captured `opb` (mod 256). At every other sequence edge `prod_hi` holds.
- R9: With no accepted start, the product registers hold their value and `done` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request a multiply; sampled at each rising edge |
| sgn_mode | input | 1 | 1 = signed (two's-complement), 0 = unsigned |
| opa | input | 8 | First operand |
| opb | input | 8 | Second operand |
| prod_hi | output | 8 | Product high byte register |
| prod_lo | output | 8 | Product low byte register |
| busy | output | 1 | Signed correction sequence in progress |
| done | output | 1 | One-cycle pulse: product registers hold the final value |

## Verification
An unsigned result and its `done` pulse are due one edge after the accepting edge. A signed result is due on the sixth edge, and the high byte may change only on the third and sixth edges. The bench keeps a behavioural step model that advances on the same rising edge as the design. It compares every product byte, `busy` and `done` on the following falling edge, so each intermediate correction is checked in the cycle it is due. Each operation also counts the cycles from its start to `done` and compares the final value against arithmetic computed directly from the operands. Extra start pulses and operand changes are injected mid-sequence to show that they have no effect.

// File: rtl/smul_pkg.sv
// Package: shared types for the sign-corrected byte multiply unit.
// Assumes: one sequence step per clock; the enum order is not decoded anywhere.
package smul_pkg;

    // Sequencer steps: idle, then five steps after the accepting edge.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_TSTB  = 3'd1,
        ST_SUBA  = 3'd2,
        ST_MOVB  = 3'd3,
        ST_TSTA  = 3'd4,
        ST_SUBB  = 3'd5
    } step_t;

    // Number of clock edges from the accepting edge to the final signed value.
    localparam int unsigned SIGNED_EDGES = 6;

endpackage

// File: rtl/smul_umul.sv
// Module: smul_umul
// Purely combinational unsigned W x W multiplier built from shifted partial
// products. Assumes the caller registers the result; no pipeline inside.
module smul_umul #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0]   mul_a,
    input  logic [W-1:0]   mul_b,
    output logic [2*W-1:0] mul_p
);
    localparam int unsigned PW = 2 * W;

    logic [PW-1:0] part [W];

    // One partial product per bit of the second operand.
    for (genvar gi = 0; gi < int'(W); gi++) begin : g_part
        assign part[gi] = mul_b[gi] ? (PW'(mul_a) << gi) : '0;
    end

    // Sum the partial products; carry beyond 2W bits cannot occur.
    always_comb begin
        mul_p = '0;
        for (int k = 0; k < int'(W); k++) begin
            mul_p = mul_p + part[k];
        end
    end

endmodule

// File: rtl/smul_hisub.sv
// Module: smul_hisub
// High-byte correction: subtracts an operand modulo 2^W when enabled,
// otherwise passes the high byte through. Any borrow is discarded.
module smul_hisub #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] hi_in,
    input  logic [W-1:0] sub_val,
    input  logic         sub_en,
    output logic [W-1:0] hi_out
);
    // Modulo subtraction with pass-through when disabled.
    always_comb begin
        hi_out = sub_en ? (hi_in - sub_val) : hi_in;
    end

endmodule

// File: rtl/smul_seq.sv
// Module: smul_seq
// Step sequencer: accepts a start only when idle, runs five steps for a
// signed request and produces registered busy/done. Assumes a synchronous
// active-low reset and one step per clock.
module smul_seq
    import smul_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic sgn_mode,
    output logic accept,
    output logic sub_a_step,
    output logic sub_b_step,
    output logic busy,
    output logic done
);
    step_t step_q;
    step_t step_d;

    // A start is taken only when no sequence is running.
    assign accept     = start && (step_q == ST_IDLE);
    assign sub_a_step = (step_q == ST_SUBA);
    assign sub_b_step = (step_q == ST_SUBB);

    // Next-step selection.
    always_comb begin
        step_d = step_q;
        unique case (step_q)
            ST_IDLE: step_d = (accept && sgn_mode) ? ST_TSTB : ST_IDLE;
            ST_TSTB: step_d = ST_SUBA;
            ST_SUBA: step_d = ST_MOVB;
            ST_MOVB: step_d = ST_TSTA;
            ST_TSTA: step_d = ST_SUBB;
            ST_SUBB: step_d = ST_IDLE;
            default: step_d = ST_IDLE;
        endcase
    end

    // Step register, busy flag and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= ST_IDLE;
            busy   <= 1'b0;
            done   <= 1'b0;
        end else begin
            step_q <= step_d;
            busy   <= (step_d != ST_IDLE);
            done   <= (accept && !sgn_mode) || (step_q == ST_SUBB);
        end
    end

    // R4: a busy period ends only with a done pulse.
    a_r4_busy_ends_in_done: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$past(sub_b_step)) |-> !done);

    // R4: done never overlaps busy.
    a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R3: the last correction step is followed by done.
    a_r3_final_step_done: assert property (@(posedge clk) disable iff (!rst_n)
        sub_b_step |=> (done && !busy));

    // R5: a start during a sequence is not accepted.
    a_r5_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !accept);

endmodule

// File: rtl/smul_unit.sv
// Module: smul_unit (top)
// Byte multiplier with a one-cycle unsigned path and a signed path built
// from the unsigned product plus two timed high-byte corrections.
// Assumes synchronous active-low reset; drives no status flags.
module smul_unit #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         sgn_mode,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    output logic [W-1:0] prod_hi,
    output logic [W-1:0] prod_lo,
    output logic         busy,
    output logic         done
);
    localparam int unsigned PW  = 2 * W;
    localparam int unsigned MSB = W - 1;

    logic          accept;
    logic          sub_a_step;
    logic          sub_b_step;
    logic [W-1:0]  opa_q;
    logic [W-1:0]  opb_q;
    logic [PW-1:0] uprod;
    logic [W-1:0]  hi_next;
    logic [W-1:0]  sub_val;
    logic          sub_en;

    smul_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .sgn_mode   (sgn_mode),
        .accept     (accept),
        .sub_a_step (sub_a_step),
        .sub_b_step (sub_b_step),
        .busy       (busy),
        .done       (done)
    );

    smul_umul #(.W(W)) u_umul (
        .mul_a (opa),
        .mul_b (opb),
        .mul_p (uprod)
    );

    // Pick the correction operand and decide from the other operand's sign.
    always_comb begin
        sub_val = sub_a_step ? opa_q : opb_q;
        sub_en  = (sub_a_step && opb_q[MSB]) || (sub_b_step && opa_q[MSB]);
    end

    smul_hisub #(.W(W)) u_hisub (
        .hi_in   (prod_hi),
        .sub_val (sub_val),
        .sub_en  (sub_en),
        .hi_out  (hi_next)
    );

    // Capture operands on an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opa_q <= '0;
            opb_q <= '0;
        end else if (accept) begin
            opa_q <= opa;
            opb_q <= opb;
        end
    end

    // Product registers: full load on accept, high-byte corrections after.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_hi <= '0;
            prod_lo <= '0;
        end else if (accept) begin
            prod_hi <= uprod[PW-1:W];
            prod_lo <= uprod[W-1:0];
        end else begin
            prod_hi <= hi_next;
        end
    end

    // R7: the low byte is untouched during a sequence.
    a_r7_lo_stable: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(prod_lo));

    // R8: the high byte holds on sequence steps without a correction.
    a_r8_hi_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !sub_a_step && !sub_b_step) |=> $stable(prod_hi));

    // R9: idle with no start holds the whole product.
    a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(prod_hi) && $stable(prod_lo) && !done));

    // R2: an unsigned start completes on the next edge without busy.
    a_r2_unsigned_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !sgn_mode) |=> (done && !busy));

    // R6: captured operands stay fixed during a sequence.
    a_r6_ops_held: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(opa_q) && $stable(opb_q)));

endmodule

// File: tb/sim_smul_unit.sv
`timescale 1ns/1ps
module sim_smul_unit;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         sgn_mode = 1'b0;
    logic [W-1:0] opa = '0;
    logic [W-1:0] opb = '0;
    logic [W-1:0] prod_hi;
    logic [W-1:0] prod_lo;
    logic         busy;
    logic         done;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    // Behavioural reference state
    int m_hi, m_lo, m_step, m_a, m_b;
    bit m_busy, m_done;

    always #4 clk = ~clk;

    smul_unit #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .sgn_mode(sgn_mode),
        .opa(opa), .opb(opb), .prod_hi(prod_hi), .prod_lo(prod_lo),
        .busy(busy), .done(done)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model: one update per rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_hi = 0; m_lo = 0; m_step = 0; m_busy = 0; m_done = 0;
            m_a = 0; m_b = 0;
        end else if (m_step == 0) begin
            m_done = 0;
            if (start) begin
                int p;
                p = int'(opa) * int'(opb);
                m_hi = (p >> 8) & 255;
                m_lo = p & 255;
                m_a = int'(opa); m_b = int'(opb);
                if (sgn_mode) begin m_step = 1; m_busy = 1; end
                else m_done = 1;
            end
        end else begin
            if (m_step == 2 && m_b >= 128) m_hi = (m_hi - m_a) & 255;
            if (m_step == 5) begin
                if (m_a >= 128) m_hi = (m_hi - m_b) & 255;
                m_done = 1; m_busy = 0; m_step = 0;
            end else m_step++;
        end
    end

    // Per-cycle comparison on the falling edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check("R8 prod_hi cycle", int'(prod_hi), m_hi);
            check("R7 prod_lo cycle", int'(prod_lo), m_lo);
            check("R4 busy cycle", int'(busy), int'(m_busy));
            check("R4 done cycle", int'(done), int'(m_done));
        end
    end

    // Run one operation; optionally disturb inputs mid-sequence.
    task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b,
                          input bit sgn, input bit disturb);
        int lat;
        int exp;
        @(negedge clk);
        opa = a; opb = b; sgn_mode = sgn; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 20) begin
            if (disturb) begin
                start = 1'b1; opa = ~a; opb = a ^ b; sgn_mode = ~sgn;
            end
            @(negedge clk);
            start = 1'b0;
            lat++;
        end
        if (sgn) begin
            exp = (int'($signed(a)) * int'($signed(b))) & 16'hFFFF;
            check(disturb ? "R5 R6 signed result" : "R3 signed result",
                  int'({prod_hi, prod_lo}), exp);
            check("R3 signed latency", lat, 6);
        end else begin
            exp = int'(a) * int'(b);
            check("R2 unsigned result", int'({prod_hi, prod_lo}), exp);
            check("R2 unsigned latency", lat, 1);
        end
        opa = '0; opb = '0; sgn_mode = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 prod_hi reset", int'(prod_hi), 0);
        check("R1 prod_lo reset", int'(prod_lo), 0);
        check("R1 busy reset", int'(busy), 0);
        check("R1 done reset", int'(done), 0);
        rst_n = 1'b1;

        run_op(8'h80, 8'h80, 1'b1, 1'b0);  // -128 x -128 = 0x4000
        run_op(8'h80, 8'h7F, 1'b1, 1'b0);  // -128 x 127
        run_op(8'h7F, 8'h80, 1'b1, 1'b0);
        run_op(8'h05, 8'h07, 1'b1, 1'b0);  // + x +
        run_op(8'hFD, 8'h09, 1'b1, 1'b0);  // - x +
        run_op(8'h0B, 8'hF2, 1'b1, 1'b0);  // + x -
        run_op(8'hF0, 8'hE1, 1'b1, 1'b0);  // - x -
        run_op(8'h00, 8'h9C, 1'b1, 1'b0);  // zero
        run_op(8'h9C, 8'h00, 1'b1, 1'b0);
        run_op(8'hFF, 8'hFF, 1'b0, 1'b0);  // unsigned max
        run_op(8'h00, 8'h55, 1'b0, 1'b0);
        run_op(8'hC3, 8'hA7, 1'b1, 1'b1);  // R5/R6 disturbance
        run_op(8'h81, 8'h3E, 1'b1, 1'b1);

        // R9: idle cycles hold the product
        repeat (4) @(negedge clk);
        check("R9 idle hold", int'({prod_hi, prod_lo}), 16'h1F7E & 16'hFFFF ^ 16'h1F7E ^ ((int'($signed(8'h81)) * 62) & 16'hFFFF));
        check("R9 idle done", int'(done), 0);

        for (int i = 0; i < 60; i++) begin
            run_op(W'($urandom), W'($urandom), i[0], 1'b0);
        end
        // Back-to-back unsigned starts
        for (int i = 0; i < 8; i++) begin
            run_op(W'($urandom), W'($urandom), 1'b0, 1'b0);
        end

        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog
    initial begin
        #200000;
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule